// File: doc/BRIEF.md
# Synchronous Serial Master Port

This block is a half-duplex synchronous serial master. A register port on the system side starts transfers and reports on them. The serial side has a clock output, a data output with its own output-enable, a data input, and two enable outputs. The data output, output-enable and data input are meant to be joined into one bidirectional pad at chip level. Moving a byte needs one register access: a write to either transmit register sends the written byte, and a read of the receive register starts a byte reception.

The serial clock runs at the system clock divided by 2, 4, 8 or 16, and it rests high between transfers. Each byte is shifted most significant bit first. The master changes its data on falling serial-clock edges and samples incoming data on rising edges. Software watches a busy flag and a complete flag by polling. A transmit write that arrives during a transfer is dropped and raises an error flag.

The register port is a plain strobed interface with no back-pressure. Every access is accepted in the cycle it is presented. Read data appears on `csr_rdata` one cycle after the read strobe and holds until the next read.

Top module: `ssm_master`

## Requirements
- R1: After reset, `sclk` is 1, `sen_a`, `sen_b` and `sdata_oe` are 0, and reads of status (address 0) and control (address 1) return 0.
- R2: During a transfer, `sclk` completes eight periods. Each period is N = 2 << S system cycles, where S is control bits [3:2] as they stood when the transfer started. Each half period lasts N/2 cycles, and busy lasts 8*N cycles.
- R3: Whenever no transfer is running, `sclk` is held at 1.
- R4: A write to address 2 or 3, made while at least one enable bit is set and the port is idle, transmits the written byte. The transmission starts at the next clock edge, and status bit 0 (busy) reads 1 while it runs. `sdata_oe` is 1 throughout. The byte goes out MSB first on `sdata_o`, and each bit changes as `sclk` falls.
- R5: A read of address 4, made while at least one enable bit is set and the port is idle, starts a reception with `sdata_oe` at 0. `sdata_i` is sampled as `sclk` rises, MSB first. The byte is returned by a later read of address 4.
- R6: A read of address 4 while both enable bits are 0 returns the stored byte and starts no transfer.
- R7: Status bit 1 (complete) is set when a transfer finishes and cleared when a new one starts.
- R8: A transmit write made while busy is ignored and sets status bit 2 (error). A status read returns the error flag and then clears it.
- R9: While both enable bits are 0, busy is held at 0. A running transfer stops with `sclk` high and complete not set, and transmit writes start nothing.
- R10: Control bit 0 drives `sen_a` and control bit 1 drives `sen_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_sel | input | 1 | Register access strobe, one cycle per access |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 3 | Register address: 0 status, 1 control, 2/3 transmit, 4 receive |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| sclk | output | 1 | Serial clock, rests high |
| sdata_o | output | 1 | Serial data driven by the master |
| sdata_oe | output | 1 | 1 while the master drives the data pad |
| sdata_i | input | 1 | Serial data from the pad |
| sen_a | output | 1 | Enable output driven by control bit 0 |
| sen_b | output | 1 | Enable output driven by control bit 1 |

## Verification
The assertions assume that every register access is a single-cycle strobe with a stable address and direction. They also assume that the slave changes `sdata_i` only after a falling `sclk` edge and holds it until the next rising edge. The stimulus keeps to these assumptions: the bench raises `csr_sel` for exactly one cycle per access, and its behavioural slave updates its data bit only on falling `sclk`. The properties also take for granted that the enable bits stay nonzero from start to finish unless an abort is intended. The only time the bench clears them mid-transfer is in the deliberate abort case.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    REG_STAT = 3'd0,
    REG_CTRL = 3'd1,
    REG_TXA  = 3'd2,
    REG_TXB  = 3'd3,
    REG_RX   = 3'd4
  } ssm_reg_e;

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;

  // control field positions
  localparam int CT_EN  = 0;
  localparam int CT_DIV = 2;
endpackage

// File: rtl/ssm_baud.sv
module ssm_baud #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             tick
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] half_m1;
  logic [CNT_W-1:0] cnt;

  // half period is latched when a transfer starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_m1 <= '0;
      cnt     <= '0;
    end else if (load) begin
      half_m1 <= (CNT_W'(1) << sel) - CNT_W'(1);
      cnt     <= '0;
    end else if (run) begin
      if (cnt == half_m1) cnt <= '0;
      else                cnt <= cnt + CNT_W'(1);
    end else begin
      cnt <= '0;
    end
  end

  assign tick = run && !load && (cnt == half_m1);

  // R2: the phase counter never runs past the latched half period
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= half_m1));
endmodule

// File: rtl/ssm_shift.sv
module ssm_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic          start_tx,
  input  logic [DW-1:0] tx_byte,
  input  logic          tick,
  input  logic          sd_i,
  output logic          busy,
  output logic          sclk,
  output logic          sd_o,
  output logic          sd_oe,
  output logic          fin,
  output logic [DW-1:0] rx_byte
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [DW-1:0] shreg;
  logic [EW-1:0] ecnt;
  logic          mode_tx;

  assign fin   = busy && tick && !abort && (ecnt == LAST);
  assign sd_oe = busy && mode_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b1;
      sd_o    <= 1'b0;
      shreg   <= '0;
      ecnt    <= '0;
      mode_tx <= 1'b0;
      rx_byte <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      sclk <= 1'b1;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      sclk    <= 1'b1;
      mode_tx <= start_tx;
      shreg   <= tx_byte;
      ecnt    <= '0;
    end else if (busy && tick) begin
      ecnt <= ecnt + EW'(1);
      if (!ecnt[0]) begin
        // falling edge: launch next bit
        sclk <= 1'b0;
        if (mode_tx) begin
          sd_o  <= shreg[DW-1];
          shreg <= {shreg[DW-2:0], 1'b0};
        end
      end else begin
        // rising edge: capture input bit
        sclk <= 1'b1;
        if (!mode_tx) shreg <= {shreg[DW-2:0], sd_i};
        if (ecnt == LAST) begin
          busy <= 1'b0;
          if (!mode_tx) rx_byte <= {shreg[DW-2:0], sd_i};
        end
      end
    end
  end

  // R3: the serial clock rests high whenever no transfer runs
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

  // R4: driven data only moves while the serial clock is low
  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sd_o)) |-> !sclk);
endmodule

// File: rtl/ssm_csr.sv
module ssm_csr
  import ssm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_sel,
  input  logic             acc_we,
  input  logic [AW-1:0]    acc_addr,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    acc_rdata,
  input  logic             busy,
  input  logic             fin,
  input  logic [DW-1:0]    rx_byte,
  output logic [1:0]       en,
  output logic [SEL_W-1:0] div,
  output logic             start,
  output logic             start_tx,
  output logic [DW-1:0]    tx_byte,
  output logic             done_o
);
  logic wr, rd, is_tx, any_en, start_rx;
  logic done_q, err_q;

  assign wr       = acc_sel && acc_we;
  assign rd       = acc_sel && !acc_we;
  assign is_tx    = (acc_addr == REG_TXA) || (acc_addr == REG_TXB);
  assign any_en   = |en;
  assign start_tx = wr && is_tx && any_en && !busy;
  assign start_rx = rd && (acc_addr == REG_RX) && any_en && !busy;
  assign start    = start_tx || start_rx;
  assign tx_byte  = acc_wdata;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      div <= '0;
    end else if (wr && acc_addr == REG_CTRL) begin
      en  <= acc_wdata[CT_EN +: 2];
      div <= acc_wdata[CT_DIV +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     done_q <= 1'b0;
    else if (start) done_q <= 1'b0;
    else if (fin)   done_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              err_q <= 1'b0;
    else if (wr && is_tx && busy)            err_q <= 1'b1;
    else if (rd && acc_addr == REG_STAT)     err_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rdata <= '0;
    end else if (rd) begin
      case (acc_addr)
        REG_STAT: begin
          acc_rdata          <= '0;
          acc_rdata[ST_BUSY] <= busy;
          acc_rdata[ST_DONE] <= done_q;
          acc_rdata[ST_ERR]  <= err_q;
        end
        REG_CTRL: acc_rdata <= DW'({div, en});
        REG_RX:   acc_rdata <= rx_byte;
        default:  acc_rdata <= '0;
      endcase
    end
  end

  // R8: a transmit write during a transfer raises the error flag
  a_r8_err_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_tx && busy) |=> err_q);
endmodule

// File: rtl/ssm_master.sv
module ssm_master
  import ssm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_sel,
  input  logic          csr_we,
  input  logic [2:0]    csr_addr,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  output logic          sclk,
  output logic          sdata_o,
  output logic          sdata_oe,
  input  logic          sdata_i,
  output logic          sen_a,
  output logic          sen_b
);
  logic [1:0]       en_w;
  logic [SEL_W-1:0] div_w;
  logic             start_w, start_tx_w, busy_w, fin_w, tick_w, done_w, abort_w;
  logic [DW-1:0]    tx_w, rx_w;

  assign abort_w = (en_w == 2'b00);
  assign sen_a   = en_w[0];
  assign sen_b   = en_w[1];

  ssm_csr #(.DW(DW), .SEL_W(SEL_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .acc_sel(csr_sel), .acc_we(csr_we), .acc_addr(csr_addr),
    .acc_wdata(csr_wdata), .acc_rdata(csr_rdata),
    .busy(busy_w), .fin(fin_w), .rx_byte(rx_w),
    .en(en_w), .div(div_w), .start(start_w), .start_tx(start_tx_w),
    .tx_byte(tx_w), .done_o(done_w)
  );

  ssm_baud #(.SEL_W(SEL_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .load(start_w), .sel(div_w),
    .run(busy_w), .tick(tick_w)
  );

  ssm_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(abort_w), .start(start_w),
    .start_tx(start_tx_w), .tx_byte(tx_w), .tick(tick_w), .sd_i(sdata_i),
    .busy(busy_w), .sclk(sclk), .sd_o(sdata_o), .sd_oe(sdata_oe),
    .fin(fin_w), .rx_byte(rx_w)
  );

  // R4: an accepted start makes the port busy on the next cycle
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> busy_w);

  // R9: with both enables off the port cannot stay busy
  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> !busy_w);

  // R6: a receive read with both enables off starts nothing
  a_r6_no_rx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel && !csr_we && csr_addr == REG_RX && abort_w) |=> !busy_w);

  // R7: a transfer that ends while enabled leaves the complete flag set
  a_r7_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_w) && $past(en_w) != 2'b00) |-> done_w);
endmodule

// File: tb/ssm_master_tb.sv
`timescale 1ns/1ps
module ssm_master_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       csr_sel, csr_we;
  logic [2:0] csr_addr;
  logic [7:0] csr_wdata, csr_rdata;
  logic       sclk, sdata_o, sdata_oe, sdata_i, sen_a, sen_b;

  always #4 clk = ~clk;

  ssm_master u_dut (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .sclk(sclk), .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(sdata_i),
    .sen_a(sen_a), .sen_b(sen_b)
  );

  // ---------------- behavioural slave ----------------
  logic [7:0] sl_byte = 8'h00;
  int         sl_mark = 0;
  int         sl_seen = 0;
  logic       sl_bit = 1'b0;
  logic [7:0] sl_got = 8'h00;
  assign sdata_i = sl_bit;

  always @(negedge sclk) begin
    sl_bit  = sl_byte[7 - ((sl_seen - sl_mark) % 8)];
    sl_seen = sl_seen + 1;
  end
  always @(posedge sclk) sl_got = {sl_got[6:0], sdata_o};

  // ---------------- reference model ----------------
  logic       m_busy, m_tx, m_done, m_err;
  logic [1:0] m_en, m_div;
  logic [7:0] m_txb, m_rx, m_rdata;
  int         m_t, m_h;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_tx = 0; m_done = 0; m_err = 0; m_en = 0; m_div = 0;
      m_txb = 0; m_rx = 0; m_rdata = 0; m_t = 0; m_h = 1;
    end else begin
      logic ob, od, oerr;
      logic [1:0] oen, odiv;
      logic [7:0] orx;
      ob = m_busy; od = m_done; oerr = m_err; oen = m_en; odiv = m_div; orx = m_rx;
      if (m_busy) begin
        if (oen == 2'b00) m_busy = 0;
        else begin
          m_t = m_t + 1;
          if (m_t == 16 * m_h) begin
            m_busy = 0; m_done = 1;
            if (!m_tx) m_rx = sl_byte;
          end
        end
      end
      if (csr_sel && csr_we) begin
        if (csr_addr == 3'd1) begin
          m_en = csr_wdata[1:0]; m_div = csr_wdata[3:2];
        end else if (csr_addr == 3'd2 || csr_addr == 3'd3) begin
          if (ob) m_err = 1;
          else if (oen != 2'b00) begin
            m_busy = 1; m_t = 0; m_tx = 1; m_txb = csr_wdata; m_done = 0;
            m_h = 1 << odiv;
          end
        end
      end
      if (csr_sel && !csr_we) begin
        case (csr_addr)
          3'd0: begin m_rdata = {5'b0, oerr, od, ob}; m_err = 0; end
          3'd1: m_rdata = {4'b0, odiv, oen};
          3'd4: begin
            m_rdata = orx;
            if (oen != 2'b00 && !ob) begin
              m_busy = 1; m_t = 0; m_tx = 0; m_done = 0; m_h = 1 << odiv;
            end
          end
          default: m_rdata = 8'h00;
        endcase
      end
    end
  end

  // ---------------- per-cycle compare ----------------
  int cyc_chk = 0, cyc_fail = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      int  k;
      logic e_sclk;
      k = m_busy ? (m_t / m_h) : 0;
      e_sclk = m_busy ? ((k % 2) == 1 ? 1'b0 : 1'b1) : 1'b1;
      cyc_chk = cyc_chk + 3;
      if (sclk !== e_sclk) begin
        cyc_fail++; $display("FAIL R2 sclk act=%b exp=%b t=%0t", sclk, e_sclk, $time);
      end
      if (sdata_oe !== (m_busy && m_tx)) begin
        cyc_fail++; $display("FAIL R4 sdata_oe act=%b exp=%b t=%0t", sdata_oe, m_busy && m_tx, $time);
      end
      if ({sen_b, sen_a} !== m_en) begin
        cyc_fail++; $display("FAIL R10 enables act=%b exp=%b t=%0t", {sen_b, sen_a}, m_en, $time);
      end
      if (m_busy && m_tx && k >= 1) begin
        cyc_chk++;
        if (sdata_o !== m_txb[7 - (k - 1) / 2]) begin
          cyc_fail++; $display("FAIL R4 sdata_o act=%b exp=%b t=%0t", sdata_o, m_txb[7 - (k - 1) / 2], $time);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    csr_sel = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_sel = 0; csr_we = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, output logic [7:0] d);
    csr_sel = 1; csr_we = 0; csr_addr = a;
    @(negedge clk);
    csr_sel = 0;
    d = csr_rdata;
    chk(req, d, m_rdata);
  endtask

  task automatic run_all();
    logic [7:0] v;
    // R1: reset state
    chk("R1 sclk", sclk, 1);
    chk("R1 enables", {sen_b, sen_a, sdata_oe}, 0);
    rd("R1 status", 3'd0, v); chk("R1 status", v, 0);
    rd("R1 ctrl", 3'd1, v);   chk("R1 ctrl", v, 0);

    // R4 R10: transmit at divide-by-2 on enable A
    wr(3'd1, 8'b0000_0001);
    chk("R10 sen_a", {sen_b, sen_a}, 2'b01);
    wr(3'd2, 8'hA5);
    rd("R4 busy", 3'd0, v); chk("R4 busy", v[0], 1);
    cyc(20);
    chk("R4 tx byte", sl_got, 8'hA5);
    chk("R3 sclk idle", sclk, 1);
    rd("R7 done", 3'd0, v); chk("R7 done", v, 8'h02);

    // R2: other divide settings via the second transmit register
    for (int s = 1; s < 4; s++) begin
      logic [7:0] b;
      b = 8'h3C ^ 8'(s * 37);
      wr(3'd1, {4'b0, 2'(s), 2'b10});
      wr(3'd3, b);
      cyc(8 * (2 << s) + 3);
      chk("R2 tx byte", sl_got, b);
      rd("R7 done", 3'd0, v); chk("R7 done", v, 8'h02);
    end

    // R5 R6: receive, then read back with enables off
    wr(3'd1, 8'b0000_0101);
    sl_byte = 8'hC6; sl_mark = sl_seen;
    rd("R5 start rx", 3'd4, v);
    rd("R7 cleared", 3'd0, v); chk("R7 cleared", v, 8'h01);
    cyc(36);
    rd("R5 done", 3'd0, v); chk("R5 done", v, 8'h02);
    wr(3'd1, 8'h00);
    rd("R6 rx data", 3'd4, v); chk("R6 rx data", v, 8'hC6);
    cyc(4);
    rd("R6 no start", 3'd0, v); chk("R6 no start", v, 8'h02);

    // R8: transmit write during busy
    wr(3'd1, 8'b0000_0011);
    wr(3'd2, 8'h96);
    cyc(3);
    wr(3'd3, 8'h00);
    cyc(20);
    chk("R8 first byte kept", sl_got, 8'h96);
    rd("R8 err set", 3'd0, v); chk("R8 err set", v, 8'h06);
    rd("R8 err clear", 3'd0, v); chk("R8 err clear", v, 8'h02);

    // R9: abort by clearing both enables
    wr(3'd1, 8'b0000_1101);
    wr(3'd2, 8'hFF);
    cyc(20);
    wr(3'd1, 8'b0000_1100);
    cyc(2);
    chk("R9 sclk high", sclk, 1);
    rd("R9 no done", 3'd0, v); chk("R9 no done", v, 8'h00);
    wr(3'd2, 8'h12);
    cyc(5);
    chk("R9 tx ignored", sdata_oe, 0);
    rd("R9 still idle", 3'd0, v); chk("R9 still idle", v, 8'h00);

    // R10: enable pins follow control bits
    wr(3'd1, 8'b0000_0010);
    chk("R10 sen_b", {sen_b, sen_a}, 2'b10);
    rd("R10 ctrl", 3'd1, v); chk("R10 ctrl", v, 8'h02);

    // R5: receive on enable B at divide-by-2
    sl_byte = 8'h3B; sl_mark = sl_seen;
    rd("R5 start rx", 3'd4, v);
    cyc(20);
    wr(3'd1, 8'h00);
    rd("R5 rx data", 3'd4, v); chk("R5 rx data", v, 8'h3B);
    cyc(4);
  endtask

  initial begin
    rst_n = 0; csr_sel = 0; csr_we = 0; csr_addr = 0; csr_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + cyc_chk, n_fail + cyc_fail);
    $finish;
  end
endmodule